// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This block is a purely combinational execution unit for bit-field operations on 64-bit operands. It merges a field from one operand into a second operand (insert), or pulls a field out of an operand and right-justifies it. The extract comes in two forms: a word form that sign-extends from bit 31 and a doubleword form that zero-extends.

Two 5-bit instruction fields describe the field. One sits in the destination-register slot and the other in the shift-amount slot. The shift-amount field always gives the starting bit. The other field gives the top bit for insert, and the field size minus one for both extracts. The result is always written back to the register named by the rt index. The instruction's rd slot only carries field geometry.

An `illegal` flag marks geometry that does not describe a valid field. The result is still produced in that case but has no defined value. Operation select, operands and field values enter in one cycle, and the result, destination and valid bit leave in that same cycle.

Top module: `bfu_bitfield_unit`

## Requirements
- R1: With op_sel = 2'b00 (insert) and msb_fld >= lsb_fld, result bits msb_fld..lsb_fld equal rs_val bits (msb_fld-lsb_fld)..0, and every other bit of result equals the same bit of rt_val, across all 64 bits.
- R2: With op_sel = 2'b01 (word extract) and lsb_fld+msb_fld+1 <= 32, result bits msb_fld..0 equal rs_val bits lsb_fld+msb_fld..lsb_fld, bits 31..msb_fld+1 are zero, and bits 63..32 all copy result bit 31.
- R3: With op_sel = 2'b10 (doubleword extract), result bits msb_fld..0 equal rs_val bits lsb_fld+msb_fld..lsb_fld and every bit above msb_fld is zero, with no sign extension.
- R4: A field of the full 32-bit width (msb_fld = 31) is extracted completely by both extract forms, with no loss of the top field bit.
- R5: dest_idx always equals rt_idx, whatever the operation and whatever value sits in msb_fld (the rd slot).
- R6: For insert, illegal is 1 exactly when msb_fld < lsb_fld.
- R7: For word extract, illegal is 1 exactly when lsb_fld+msb_fld+1 > 32. For doubleword extract, illegal is 0 for every 5-bit field pair.
- R8: op_sel = 2'b11 is reserved; it gives illegal = 1 and result = 0.
- R9: valid_out equals valid_in, and all outputs follow their inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_in | input | 1 | Operation request valid |
| op_sel | input | 2 | 00 insert, 01 word extract, 10 doubleword extract, 11 reserved |
| rs_val | input | 64 | Source operand supplying the field |
| rt_val | input | 64 | Operand receiving the field on insert |
| msb_fld | input | 5 | Field from the rd slot: top bit (insert) or size minus one (extract) |
| lsb_fld | input | 5 | Field from the shift-amount slot: starting bit |
| rt_idx | input | 5 | Register number of the rt operand |
| valid_out | output | 1 | Result valid, same cycle as valid_in |
| result | output | 64 | Operation result |
| dest_idx | output | 5 | Write-back register number |
| illegal | output | 1 | Field geometry invalid; result undefined |

## Verification
The hardest behaviour to reach is the sign extension of the word extract. It appears only when the field is exactly 32 bits wide (msb_fld = 31, lsb_fld = 0) and rs_val bit 31 is set. Uniformly drawn field values hit that case about once in a thousand draws. The random stimulus therefore draws each field value from a biased pool that favours 0 and 31. Directed cases then place a set and a clear bit 31 at that exact geometry, and also a 31-bit field whose top bit must not sign-extend.

// File: rtl/bfu_pkg.sv
`timescale 1ns/1ps
package bfu_pkg;

    typedef enum logic [1:0] {
        BF_INSERT    = 2'b00,
        BF_EXTRACT_W = 2'b01,
        BF_EXTRACT_D = 2'b10,
        BF_RESERVED  = 2'b11
    } bf_op_e;

endpackage

// File: rtl/bfu_field_ctl.sv
`timescale 1ns/1ps
// Turns the two 5-bit instruction fields into a bit range [lo, hi) and
// a legality flag, per operation.
module bfu_field_ctl
    import bfu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FLD_W  = 5,
    parameter int BND_W  = 7
) (
    input  bf_op_e             op,
    input  logic [FLD_W-1:0]   msb_fld,
    input  logic [FLD_W-1:0]   lsb_fld,
    output logic [BND_W-1:0]   range_lo,
    output logic [BND_W-1:0]   range_hi,
    output logic               bad_geom
);

    localparam logic [BND_W-1:0] FULL_LIM = BND_W'(DATA_W);
    localparam logic [BND_W-1:0] HALF_LIM = BND_W'(DATA_W / 2);
    localparam logic [BND_W-1:0] ONE      = BND_W'(1);

    logic [BND_W-1:0] msb_e;
    logic [BND_W-1:0] lsb_e;
    logic [BND_W-1:0] top_d;
    logic [BND_W-1:0] end_d;

    assign msb_e = BND_W'(msb_fld);
    assign lsb_e = BND_W'(lsb_fld);
    assign top_d = msb_e + ONE;
    assign end_d = lsb_e + msb_e + ONE;

    always_comb begin
        range_lo = '0;
        range_hi = '0;
        bad_geom = 1'b0;
        unique case (op)
            BF_INSERT: begin
                bad_geom = (msb_e < lsb_e) || (top_d > FULL_LIM);
                range_lo = lsb_e;
                range_hi = (msb_e < lsb_e) ? lsb_e : top_d;
            end
            BF_EXTRACT_W: begin
                bad_geom = end_d > HALF_LIM;
                range_hi = top_d;
            end
            BF_EXTRACT_D: begin
                bad_geom = end_d > FULL_LIM;
                range_hi = top_d;
            end
            default: begin
                bad_geom = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bfu_range_mask.sv
`timescale 1ns/1ps
// Mask with ones at every bit position p where lo <= p < hi.
// Built by comparison, so a range ending at DATA_W needs no wide shift.
module bfu_range_mask #(
    parameter int DATA_W = 64,
    parameter int BND_W  = 7
) (
    input  logic [BND_W-1:0]  range_lo,
    input  logic [BND_W-1:0]  range_hi,
    output logic [DATA_W-1:0] mask
);

    for (genvar p = 0; p < DATA_W; p++) begin : g_bit
        localparam logic [BND_W-1:0] POS = BND_W'(p);
        assign mask[p] = (POS >= range_lo) && (POS < range_hi);
    end

endmodule

// File: rtl/bfu_barrel.sv
`timescale 1ns/1ps
// Logarithmic shifter, direction chosen by parameter.
module bfu_barrel #(
    parameter int DATA_W     = 64,
    parameter int SH_W       = 5,
    parameter bit SHIFT_LEFT = 1'b0
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amount,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP >= DATA_W) begin : g_flush
            assign stage[k+1] = amount[k] ? '0 : stage[k];
        end else if (SHIFT_LEFT) begin : g_left
            assign stage[k+1] = amount[k] ? (stage[k] << STEP) : stage[k];
        end else begin : g_right
            assign stage[k+1] = amount[k] ? (stage[k] >> STEP) : stage[k];
        end
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/bfu_bitfield_unit.sv
`timescale 1ns/1ps
module bfu_bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FLD_W  = 5,
    parameter int IDX_W  = 5
) (
    input  logic              valid_in,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [FLD_W-1:0]  msb_fld,
    input  logic [FLD_W-1:0]  lsb_fld,
    input  logic [IDX_W-1:0]  rt_idx,
    output logic              valid_out,
    output logic [DATA_W-1:0] result,
    output logic [IDX_W-1:0]  dest_idx,
    output logic              illegal
);

    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int BND_W  = (CNT_W > FLD_W + 2) ? CNT_W : FLD_W + 2;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [IDX_W-1:0]  dest;
        logic [DATA_W-1:0] data;
    } bfu_out_t;

    bf_op_e            op_e;
    logic [BND_W-1:0]  range_lo;
    logic [BND_W-1:0]  range_hi;
    logic              bad_geom;
    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] rs_right;
    logic [DATA_W-1:0] rs_left;
    logic [DATA_W-1:0] ext_field;
    bfu_out_t          out_d;

    assign op_e = bf_op_e'(op_sel);

    bfu_field_ctl #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .BND_W  (BND_W)
    ) ctl_i (
        .op       (op_e),
        .msb_fld  (msb_fld),
        .lsb_fld  (lsb_fld),
        .range_lo (range_lo),
        .range_hi (range_hi),
        .bad_geom (bad_geom)
    );

    bfu_range_mask #(
        .DATA_W (DATA_W),
        .BND_W  (BND_W)
    ) mask_i (
        .range_lo (range_lo),
        .range_hi (range_hi),
        .mask     (field_mask)
    );

    bfu_barrel #(
        .DATA_W     (DATA_W),
        .SH_W       (FLD_W),
        .SHIFT_LEFT (1'b0)
    ) shr_i (
        .din    (rs_val),
        .amount (lsb_fld),
        .dout   (rs_right)
    );

    bfu_barrel #(
        .DATA_W     (DATA_W),
        .SH_W       (FLD_W),
        .SHIFT_LEFT (1'b1)
    ) shl_i (
        .din    (rs_val),
        .amount (lsb_fld),
        .dout   (rs_left)
    );

    assign ext_field = rs_right & field_mask;

    always_comb begin
        out_d         = '0;
        out_d.valid   = valid_in;
        out_d.illegal = bad_geom;
        out_d.dest    = rt_idx;
        unique case (op_e)
            BF_INSERT:
                out_d.data = (rt_val & ~field_mask) | (rs_left & field_mask);
            BF_EXTRACT_W:
                out_d.data = {{(DATA_W - HALF_W){ext_field[HALF_W-1]}},
                              ext_field[HALF_W-1:0]};
            BF_EXTRACT_D:
                out_d.data = ext_field;
            default:
                out_d.data = '0;
        endcase
    end

    assign valid_out = out_d.valid;
    assign illegal   = out_d.illegal;
    assign dest_idx  = out_d.dest;
    assign result    = out_d.data;

endmodule

// File: rtl/bfu_bitfield_unit_chk.sv
`timescale 1ns/1ps
module bfu_bitfield_unit_chk #(
    parameter int DATA_W = 64,
    parameter int FLD_W  = 5,
    parameter int IDX_W  = 5
) (
    input logic              valid_in,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic [FLD_W-1:0]  msb_fld,
    input logic [FLD_W-1:0]  lsb_fld,
    input logic [IDX_W-1:0]  rt_idx,
    input logic              valid_out,
    input logic [DATA_W-1:0] result,
    input logic [IDX_W-1:0]  dest_idx,
    input logic              illegal
);

    localparam int HALF_W = DATA_W / 2;

    logic [FLD_W:0]    top_ext;
    logic [DATA_W-1:0] diff_rt;
    logic [DATA_W-1:0] low_keep;

    assign top_ext  = {1'b0, msb_fld} + {{FLD_W{1'b0}}, 1'b1};
    assign diff_rt  = result ^ rt_val;
    assign low_keep = (DATA_W'(1) << lsb_fld) - DATA_W'(1);

    always_comb begin
        // R9
        valid_pass_chk: assert (valid_out == valid_in)
            else $error("valid_out does not follow valid_in");
        // R5
        dest_rt_chk: assert (dest_idx == rt_idx)
            else $error("destination is not the rt index");
        // R6
        if (op_sel == 2'b00) begin
            ins_illegal_chk: assert (illegal == (msb_fld < lsb_fld))
                else $error("insert legality flag wrong");
        end
        // R1
        if (op_sel == 2'b00 && !illegal) begin
            ins_keep_chk: assert (((diff_rt >> top_ext) == '0) &&
                                  ((diff_rt & low_keep) == '0))
                else $error("insert disturbed bits outside the field");
        end
        // R2
        if (op_sel == 2'b01 && !illegal) begin
            ext_sign_chk: assert (result[DATA_W-1:HALF_W] ==
                                  {(DATA_W - HALF_W){result[HALF_W-1]}})
                else $error("word extract upper half not a sign copy");
        end
        // R3
        if (op_sel == 2'b10) begin
            dext_zero_chk: assert (!illegal && ((result >> top_ext) == '0))
                else $error("doubleword extract has bits above the field");
        end
        // R8
        if (op_sel == 2'b11) begin
            rsvd_flag_chk: assert (illegal && result == '0)
                else $error("reserved operation not flagged");
        end
    end

endmodule

bind bfu_bitfield_unit bfu_bitfield_unit_chk #(
    .DATA_W (DATA_W),
    .FLD_W  (FLD_W),
    .IDX_W  (IDX_W)
) chk_i (
    .valid_in  (valid_in),
    .op_sel    (op_sel),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .msb_fld   (msb_fld),
    .lsb_fld   (lsb_fld),
    .rt_idx    (rt_idx),
    .valid_out (valid_out),
    .result    (result),
    .dest_idx  (dest_idx),
    .illegal   (illegal)
);

// File: tb/bfu_bitfield_unit_tb_top.sv
`timescale 1ns/1ps
module bfu_bitfield_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic [4:0]  msb_fld = '0;
    logic [4:0]  lsb_fld = '0;
    logic [4:0]  rt_idx = '0;
    logic        valid_out;
    logic [63:0] result;
    logic [4:0]  dest_idx;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bfu_bitfield_unit dut_i (
        .valid_in  (valid_in),
        .op_sel    (op_sel),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .msb_fld   (msb_fld),
        .lsb_fld   (lsb_fld),
        .rt_idx    (rt_idx),
        .valid_out (valid_out),
        .result    (result),
        .dest_idx  (dest_idx),
        .illegal   (illegal)
    );

    function automatic logic [63:0] exp_result(input logic [1:0] op,
        input logic [63:0] rs, input logic [63:0] rt, input int msb, input int lsb);
        logic [63:0] r;
        r = '0;
        if (op == 2'b00) begin
            for (int i = 0; i < 64; i++) begin
                if (i >= lsb && i <= msb) r[i] = rs[i - lsb];
                else r[i] = rt[i];
            end
        end else if (op == 2'b01 || op == 2'b10) begin
            for (int i = 0; i <= msb; i++) begin
                if (lsb + i < 64) r[i] = rs[lsb + i];
            end
            if (op == 2'b01 && r[31]) r[63:32] = '1;
        end
        return r;
    endfunction

    function automatic logic exp_illegal(input logic [1:0] op, input int msb, input int lsb);
        case (op)
            2'b00:   return msb < lsb;
            2'b01:   return (lsb + msb + 1) > 32;
            2'b10:   return (lsb + msb + 1) > 64;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [4:0] pick_fld();
        int sel;
        sel = int'($urandom % 4);
        if (sel == 0) return 5'd0;
        if (sel == 1) return 5'd31;
        return 5'($urandom);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [1:0] op, input logic [63:0] rs,
                         input logic [63:0] rt, input logic [4:0] msb,
                         input logic [4:0] lsb, input logic [4:0] idx);
        @(negedge clk);
        valid_in = v; op_sel = op; rs_val = rs; rt_val = rt;
        msb_fld = msb; lsb_fld = lsb; rt_idx = idx;
        #2;
    endtask

    task automatic check_all(input string req);
        logic ill;
        ill = exp_illegal(op_sel, int'(msb_fld), int'(lsb_fld));
        check({req, " illegal"}, 64'(illegal), 64'(ill));
        if (!ill || op_sel == 2'b11)
            check({req, " result"}, result,
                  exp_result(op_sel, rs_val, rt_val, int'(msb_fld), int'(lsb_fld)));
        check("R5 dest", 64'(dest_idx), 64'(rt_idx));
        check("R9 valid", 64'(valid_out), 64'(valid_in));
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED_B17F));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R9 idle valid_out", 64'(valid_out), 64'(0));

        // R1: single bit and full 32-bit insert keeping rt upper bits
        apply(1, 2'b00, 64'h1, 64'hFFFF_FFFF_0000_0000, 5'd0, 5'd0, 5'd7);
        check_all("R1 ins single");
        apply(1, 2'b00, 64'hDEAD_BEEF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 5'd0, 5'd3);
        check_all("R1 ins full word");
        apply(1, 2'b00, 64'h5, 64'h0, 5'd30, 5'd28, 5'd9);
        check_all("R1 ins high");
        // R6: msb below lsb
        apply(1, 2'b00, 64'h5, 64'h0, 5'd3, 5'd5, 5'd9);
        check_all("R6 ins reversed");
        // R2/R4: full 32-bit word extract, bit 31 set and clear
        apply(1, 2'b01, 64'h0000_0000_8000_0001, 64'h0, 5'd31, 5'd0, 5'd1);
        check("R2 R4 sext", result, 64'hFFFF_FFFF_8000_0001);
        apply(1, 2'b01, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 5'd31, 5'd0, 5'd1);
        check("R2 R4 no sext", result, 64'h0000_0000_7FFF_FFFF);
        // R2: 31-bit field whose top bit is set must not sign-extend
        apply(1, 2'b01, 64'h0000_0000_8000_0000, 64'h0, 5'd30, 5'd1, 5'd2);
        check("R2 narrow", result, 64'h0000_0000_4000_0000);
        // R7: word extract past bit 31
        apply(1, 2'b01, 64'h0, 64'h0, 5'd31, 5'd1, 5'd2);
        check("R7 ext overflow", 64'(illegal), 64'(1));
        // R3/R4: doubleword extract, zero extension
        apply(1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'd31, 5'd31, 5'd4);
        check("R3 R4 dext high", result, 64'h0000_0000_FFFF_FFFF);
        check("R7 dext legal", 64'(illegal), 64'(0));
        apply(1, 2'b10, 64'h0000_0000_8000_0000, 64'h0, 5'd31, 5'd0, 5'd4);
        check("R3 dext zext", result, 64'h0000_0000_8000_0000);
        // R8: reserved
        apply(1, 2'b11, 64'hFFFF, 64'hFFFF, 5'd4, 5'd0, 5'd6);
        check_all("R8 reserved");
        // R5: rd slot value differs from rt index
        apply(1, 2'b10, 64'h0, 64'h0, 5'd17, 5'd0, 5'd22);
        check("R5 dest not rd", 64'(dest_idx), 64'd22);
        // R9: valid deasserted passes through
        apply(0, 2'b00, 64'h0, 64'h0, 5'd0, 5'd0, 5'd0);
        check("R9 valid low", 64'(valid_out), 64'(0));

        for (int n = 0; n < 3000; n++) begin
            apply(1'($urandom), 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                  pick_fld(), pick_fld(), 5'($urandom));
            case (op_sel)
                2'b00:   check_all("R1 R6 rand");
                2'b01:   check_all("R2 R7 rand");
                2'b10:   check_all("R3 R7 rand");
                default: check_all("R8 rand");
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule